// File: doc/BRIEF.md
# Security Register Serial Read Engine

This block is the read path of a serial-flash slave for three one-time security registers of 1024 bytes each. A host selects the device by pulling chip select low. It sends the read opcode 48H, a 24-bit address and one dummy byte. The device then returns register bytes on the serial output until chip select is released. All serial inputs are oversampled by the block's own system clock. SCLK is therefore a data input here, not a clock.

The engine drives a synchronous byte-read port of the storage array. A one-cycle read strobe and an address go out, and the byte comes back on the next clock. The starting byte may be any location in the selected register. The byte offset increases after every byte and wraps inside the register. Each following byte is fetched while the last bit of the current byte is on the line, so bytes follow each other with no gap. Addresses that name no register produce all-ones bytes without touching the array.

Top module: `secreg_read`

## Requirements
- R1: While chip select is low, the first 8 bits sampled on rising SCLK edges form the opcode, MSB first. Only opcode 48H starts a read. The next 24 rising edges carry the address MSB first, and the 8 after that are a dummy byte whose value is ignored.
- R2: Data bits change on SO only after a falling SCLK edge and go out MSB first. The first bit follows the falling edge right after the last dummy bit, and further bytes continue with no gap. SCLK must stay high and low for at least 3 clock periods each.
- R3: so_oe is 0 while chip select is high and during the opcode, address and dummy phases. It is 1 during data output.
- R4: Each byte comes from the current offset, and the offset then increases by one. A read of N bytes performs exactly N+1 single-cycle storage reads: the first during the dummy phase, and one more after the last bit of every byte.
- R5: The byte offset is address bits 9..0. After offset 3FFH the next byte comes from offset 000H of the same register. The register choice taken from the start address never changes during a read, even when bits 9..8 of the offset change.
- R6: A start address with bits 23..16 equal to 00H and bits 15..8 equal to 01H, 02H or 03H selects register 1, 2 or 3. The storage address is 12 bits wide: bits 11..10 hold the register number and bits 9..0 hold the byte offset.
- R7: Any other start address returns FFH for every byte, and mem_re stays 0 for the whole read.
- R8: An opcode other than 48H produces no output (so_oe stays 0) and no storage read until chip select goes high.
- R9: Raising chip select at any point ends the transfer. so_oe falls within 4 clocks, and the next selection starts again with an opcode.
- R10: While reset is held, so_oe and mem_re are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| mem_re | output | 1 | Storage read strobe, one cycle per byte |
| mem_addr | output | 12 | Storage address: register number (11..10), offset (9..0) |
| mem_rdata | input | 8 | Storage read data, valid the cycle after mem_re |

## Verification
A miscounted header shows up in the very first data byte. It appears as a shifted byte or as so_oe rising too early, during the dummy phase. A wrong offset or a lost register select shows within one byte time of the fault. It is most visible across the 3FFH wrap and across a change of offset bits 9..8. A fetch that fires twice, or not at all, changes the storage read count as soon as the transfer ends. It also puts a stale byte on SO one byte later.

// File: rtl/secreg_rd_pkg.sv
package secreg_rd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/secreg_rd_sync.sv
module secreg_rd_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int CW = W * STAGES;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_n = d;
    end else begin : g_many
      assign chain_n = {chain_q[CW-W-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[CW-1 -: W];

endmodule

// File: rtl/secreg_rd_front.sv
module secreg_rd_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  output logic sel_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi
);

  logic [2:0] pins_raw;
  logic [2:0] pins_syn;
  logic       sck_q;
  logic       sck_n;

  assign pins_raw = {cs_n, sclk, si};

  secreg_rd_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_syn)
  );

  assign sck_n = pins_syn[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_n;
  end

  assign sel_act  = ~pins_syn[2];
  assign sck_rise =  pins_syn[1] & ~sck_q;
  assign sck_fall = ~pins_syn[1] &  sck_q;
  assign sdi      =  pins_syn[0];

endmodule

// File: rtl/secreg_rd_ctrl.sv
module secreg_rd_ctrl
  import secreg_rd_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          OFF_W    = 10,
  parameter int          BYTE_W   = 8,
  parameter int          NUM_REGS = 3,
  parameter logic [7:0]  OPCODE   = 8'h48,
  localparam int         SEL_W    = $clog2(NUM_REGS + 1),
  localparam int         MEM_AW   = SEL_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act,
  input  logic              sck_rise,
  input  logic              sdi,
  input  logic              byte_last,
  input  logic [BYTE_W-1:0] mem_rdata,
  output phase_e            phase,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              ld,
  output logic [BYTE_W-1:0] ld_val
);

  localparam int CNT_W = $clog2(ADDR_W);

  phase_e             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [ADDR_W-2:0]  sr_q, sr_n;
  logic [ADDR_W-1:0]  sr_nxt;
  logic               hit_q, hit_n;
  logic [SEL_W-1:0]   reg_q, reg_n;
  logic [OFF_W-1:0]   off_q, off_n;
  logic               pend_q, pend_n;
  logic               vld_q, vld_n;
  logic [BYTE_W-1:0]  page;
  logic               hi_ok;
  logic               pg_ok;

  assign sr_nxt = {sr_q, sdi};
  assign page   = sr_nxt[2*BYTE_W-1:BYTE_W];
  assign hi_ok  = (sr_nxt[ADDR_W-1:2*BYTE_W] == '0);
  assign pg_ok  = (page != '0) && (page <= BYTE_W'(NUM_REGS));

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sr_n    = sr_q;
    hit_n   = hit_q;
    reg_n   = reg_q;
    off_n   = off_q;
    pend_n  = 1'b0;
    vld_n   = pend_q;
    if (!sel_act) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE, PH_CMD: begin
          phase_n = PH_CMD;
          if (sck_rise) begin
            sr_n  = sr_nxt[ADDR_W-2:0];
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              cnt_n   = '0;
              phase_n = (sr_nxt[BYTE_W-1:0] == OPCODE) ? PH_ADDR : PH_SKIP;
            end
          end
        end
        PH_ADDR: begin
          if (sck_rise) begin
            sr_n  = sr_nxt[ADDR_W-2:0];
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_n   = '0;
              phase_n = PH_DUMMY;
              hit_n   = hi_ok && pg_ok;
              reg_n   = page[SEL_W-1:0];
              off_n   = sr_nxt[OFF_W-1:0];
              pend_n  = 1'b1;
            end
          end
        end
        PH_DUMMY: begin
          if (sck_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              cnt_n   = '0;
              phase_n = PH_DATA;
            end
          end
        end
        PH_DATA: begin
          if (byte_last) begin
            off_n  = off_q + OFF_W'(1);
            pend_n = 1'b1;
          end
        end
        default: begin
          phase_n = PH_SKIP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      hit_q   <= 1'b0;
      reg_q   <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      hit_q   <= hit_n;
      reg_q   <= reg_n;
      off_q   <= off_n;
      pend_q  <= pend_n;
      vld_q   <= vld_n;
    end
  end

  assign phase    = phase_q;
  assign mem_re   = pend_q & hit_q;
  assign mem_addr = {reg_q, off_q};
  assign ld       = vld_q;
  assign ld_val   = hit_q ? mem_rdata : {BYTE_W{1'b1}};

endmodule

// File: rtl/secreg_rd_tx.sv
module secreg_rd_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_data,
  input  logic              sck_fall,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_val,
  output logic              so,
  output logic              so_oe,
  output logic              byte_last
);

  localparam int IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] byte_q, byte_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              so_q, so_n;
  logic              oe_q, oe_n;

  always_comb begin
    byte_n = ld ? ld_val : byte_q;
    idx_n  = idx_q;
    so_n   = so_q;
    oe_n   = oe_q;
    if (!in_data) begin
      oe_n  = 1'b0;
      idx_n = '0;
    end else if (sck_fall) begin
      so_n  = byte_q[IDX_W'(BYTE_W - 1) - idx_q];
      oe_n  = 1'b1;
      idx_n = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      idx_q  <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      byte_q <= byte_n;
      idx_q  <= idx_n;
      so_q   <= so_n;
      oe_q   <= oe_n;
    end
  end

  assign so        = so_q;
  assign so_oe     = oe_q;
  assign byte_last = in_data & sck_fall & (idx_q == IDX_W'(BYTE_W - 1));

endmodule

// File: rtl/secreg_read.sv
module secreg_read
  import secreg_rd_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          OFF_W       = 10,
  parameter int          BYTE_W      = 8,
  parameter int          NUM_REGS    = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  OPCODE      = 8'h48,
  localparam int         SEL_W       = $clog2(NUM_REGS + 1),
  localparam int         MEM_AW      = SEL_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata
);

  logic              sel_act;
  logic              sck_rise;
  logic              sck_fall;
  logic              sdi;
  logic              byte_last;
  logic              ld;
  logic [BYTE_W-1:0] ld_val;
  logic              in_data;
  phase_e            phase_w;

  secreg_rd_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .si      (si),
    .sel_act (sel_act),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .sdi     (sdi)
  );

  secreg_rd_ctrl #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .BYTE_W  (BYTE_W),
    .NUM_REGS(NUM_REGS),
    .OPCODE  (OPCODE)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_act  (sel_act),
    .sck_rise (sck_rise),
    .sdi      (sdi),
    .byte_last(byte_last),
    .mem_rdata(mem_rdata),
    .phase    (phase_w),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .ld       (ld),
    .ld_val   (ld_val)
  );

  assign in_data = (phase_w == PH_DATA) & sel_act;

  secreg_rd_tx #(
    .BYTE_W(BYTE_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .sck_fall (sck_fall),
    .ld       (ld),
    .ld_val   (ld_val),
    .so       (so),
    .so_oe    (so_oe),
    .byte_last(byte_last)
  );

endmodule

// File: rtl/secreg_read_chk.sv
module secreg_read_chk
  import secreg_rd_pkg::*;
#(
  parameter int MEM_AW = 12,
  parameter int OFF_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              so,
  input logic              so_oe,
  input logic              mem_re,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              sck_fall,
  input phase_e            phase
);

  AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (phase == PH_DATA)); // R3

  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !so_oe); // R9

  AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so)); // R2

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re); // R4

  AST_RD_VALID_REG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr[MEM_AW-1:OFF_W] != '0)); // R6

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!so_oe && !mem_re); // R10
    end
  end

endmodule

bind secreg_read secreg_read_chk #(
  .MEM_AW(MEM_AW),
  .OFF_W (OFF_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .so      (so),
  .so_oe   (so_oe),
  .mem_re  (mem_re),
  .mem_addr(mem_addr),
  .sck_fall(sck_fall),
  .phase   (phase_w)
);

// File: tb/secreg_read_tb_top.sv
`timescale 1ns/1ps
module secreg_read_tb_top;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        si = 1'b0;
  logic        so;
  logic        so_oe;
  logic        mem_re;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int          n_chk = 0;
  int          n_bad = 0;
  int          rd_cnt = 0;
  int          mon_phase = 0;
  int          hdr_oe_bad = 0;
  int          bitn = 0;
  logic [7:0]  acc = 8'h00;
  logic        oe_ok = 1'b1;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  e_byte;
  string       e_tag;
  bit          done = 0;

  always #2 clk = ~clk;

  secreg_read dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .si       (si),
    .so       (so),
    .so_oe    (so_oe),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_val(input logic [11:0] a);
    return 8'(a * 37) ^ 8'(a >> 4) ^ 8'hC3;
  endfunction

  function automatic bit addr_ok(input logic [23:0] a);
    return (a[23:16] == 8'h00) && (a[15:8] >= 8'h01) && (a[15:8] <= 8'h03);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [23:0] a, input int k);
    logic [9:0] off;
    off = a[9:0] + 10'(k);
    if (!addr_ok(a)) return 8'hFF;
    return mem_val({a[9:8] & 2'b00 | a[9:8] & 2'b00 | 2'(a[15:8]), off});
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= mem_val(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge sclk) begin
    if (mon_phase == 1) begin
      if (so_oe !== 1'b0) hdr_oe_bad++;
    end else if (mon_phase == 2) begin
      acc = {acc[6:0], so};
      if (so_oe !== 1'b1) oe_ok = 1'b0;
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected byte", int'(acc), 0);
        end else begin
          e_byte = exp_q.pop_front();
          e_tag  = tag_q.pop_front();
          check((acc === e_byte) && oe_ok, e_tag, "data byte",
                int'({oe_ok, acc}), int'({1'b1, e_byte}));
        end
        oe_ok = 1'b1;
      end
    end
  end

  task automatic clk_bit(input logic b);
    si = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    for (int i = 7; i >= 0; i--) clk_bit(op[i]);
    for (int i = 23; i >= 0; i--) clk_bit(a[i]);
    for (int i = 0; i < 8; i++) clk_bit(1'b1);
  endtask

  task automatic select_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_txn(input logic [23:0] a, input int n, input string tag);
    int r0;
    r0 = rd_cnt;
    hdr_oe_bad = 0;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp_byte(a, k));
      tag_q.push_back(tag);
    end
    select_low();
    mon_phase = 1;
    send_hdr(8'h48, a);
    bitn  = 0;
    oe_ok = 1'b1;
    mon_phase = 2;
    for (int k = 0; k < n * 8; k++) clk_bit(1'b0);
    mon_phase = 0;
    deselect();
    check(hdr_oe_bad == 0, "R3", "so_oe during header", hdr_oe_bad, 0);
    check(so_oe == 1'b0, "R3", "so_oe after deselect", int'(so_oe), 0);
    check(exp_q.size() == 0, tag, "bytes missing", exp_q.size(), 0);
    if (addr_ok(a))
      check(rd_cnt - r0 == n + 1, "R4", "storage reads", rd_cnt - r0, n + 1);
    else
      check(rd_cnt == r0, "R7", "storage reads on bad address", rd_cnt - r0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(so_oe == 1'b0, "R10", "so_oe in reset", int'(so_oe), 0);
    check(mem_re == 1'b0, "R10", "mem_re in reset", int'(mem_re), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    read_txn(24'h000100, 3, "R1");
    read_txn(24'h000234, 20, "R2");
    read_txn(24'h0001FF, 3, "R5");
    read_txn(24'h0003FE, 5, "R5");
    read_txn(24'h000377, 2, "R6");
    read_txn(24'h010100, 3, "R7");
    read_txn(24'h000000, 2, "R7");
    read_txn(24'h000400, 2, "R7");

    begin : r8_wrong_op
      int r0;
      r0 = rd_cnt;
      hdr_oe_bad = 0;
      select_low();
      mon_phase = 1;
      send_hdr(8'h9F, 24'h000100);
      for (int k = 0; k < 16; k++) clk_bit(1'b0);
      mon_phase = 0;
      deselect();
      check(hdr_oe_bad == 0, "R8", "so_oe after other opcode", hdr_oe_bad, 0);
      check(rd_cnt == r0, "R8", "reads after other opcode", rd_cnt - r0, 0);
    end

    begin : r9_abort
      exp_q.push_back(exp_byte(24'h000210, 0));
      tag_q.push_back("R9");
      select_low();
      mon_phase = 1;
      send_hdr(8'h48, 24'h000210);
      bitn  = 0;
      oe_ok = 1'b1;
      mon_phase = 2;
      for (int k = 0; k < 11; k++) clk_bit(1'b0);
      mon_phase = 0;
      bitn = 0;
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      check(so_oe == 1'b0, "R9", "so_oe after mid-byte deselect", int'(so_oe), 0);
      repeat (4) @(negedge clk);
    end
    read_txn(24'h000211, 2, "R9");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "WDOG", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule